// File: doc/BRIEF.md
# Audio Clock Ratio Divider

This block runs on a fixed master audio clock and produces the timing for a serial audio port. A two-bit code selects how many master cycles make one sample period at the base (48 kHz family) rate. A two-bit rate mode then doubles or quadruples the sample rate while the master clock keeps its frequency, so the number of master cycles per frame shrinks by 2 or 4. The outputs are a frame-clock level, a frame-start strobe, a bit-clock strobe at 64 per frame, a core-clock enable for the direct-master-clock case, and an error flag.

Every output is a clock enable or a level in the master clock domain. A new code, rate or mode is sampled only at the end of the running frame, so the frame clock never produces a short period. When the effective cycles per bit are fractional, bit periods take two lengths that differ by one cycle, and an error accumulator spaces them so that each frame still has exactly 64 bits.

Top module: `aclk_ratio_div`

## Requirements
- R1: The frame length N in master cycles is the base ratio shifted right by the rate mode. The base ratios for mcs_i 00/01/10/11 are 256/384/512/768. For rate_i, 00 shifts by 0, 01 shifts by 1 and 10 shifts by 2. frame_stb_o pulses for one cycle at the start of each frame.
- R2: lrclk_o is high for the first N/2 cycles of a frame and low for the last N/2.
- R3: With bit-clock generation active, bclk_stb_o pulses exactly 64 times per frame. The first pulse falls on the frame's first cycle, and the gaps between pulses are floor(N/64) or ceil(N/64) cycles.
- R4: bclk_stb_o pulses only when bclk_gen_i is 1 and port_master_i is 0 (serial port is the slave). In any other case it stays low while lrclk_o runs on unchanged.
- R5: A change to mcs_i, rate_i, clk_sel_i, bclk_gen_i or port_master_i does not alter the frame in progress. It takes effect from the next frame.
- R6: rate_i = 11 is invalid, and clk_sel_i = 1 with mcs_i other than 10 is invalid. When an invalid setting is sampled, err_o goes high and lrclk_o, frame_stb_o, bclk_stb_o and core_en_o are held low.
- R7: With clk_sel_i = 1 (direct master clock at 512 fs base), core_en_o is high on every cycle of a running frame. With clk_sel_i = 0 (PLL-driven core), core_en_o stays low.
- R8: During reset all outputs are low. The first valid setting is sampled on the first clock edge after reset is released, and frame_stb_o is high in the cycle that follows.
- R9: While a setting is invalid, the inputs are sampled on every edge. A valid setting clears err_o and starts a frame in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcs_i | input | 2 | Base master-clock ratio select |
| rate_i | input | 2 | Sample-rate family: 00 base, 01 double, 10 quad, 11 invalid |
| clk_sel_i | input | 1 | 1 selects the direct master clock as the core clock, 0 selects the PLL |
| bclk_gen_i | input | 1 | Enables internal bit-clock generation |
| port_master_i | input | 1 | Serial port is the master when 1 and the slave when 0 |
| lrclk_o | output | 1 | Frame clock level |
| frame_stb_o | output | 1 | One-cycle strobe at each frame start |
| bclk_stb_o | output | 1 | One-cycle strobe at each bit start |
| core_en_o | output | 1 | Core clock enable in direct mode |
| err_o | output | 1 | Invalid setting sampled |

## Verification
The hardest case to reach is a setting change that lands in the middle of a frame. It must leave that frame alone and apply cleanly at the boundary. The stimulus changes the inputs in the first cycle of a fresh frame, so the full old frame is still to run, and the scoreboard expects one frame of the old setting followed by frames of the new one. The fractional case (384 base at quad rate, 1.5 cycles per bit) is covered by checking the smallest and largest bit gap in each frame. Invalid settings are applied the same way, and the bench then checks that all outputs stay quiet and that recovery starts one cycle after a valid setting.

// File: rtl/acd_pkg.sv
package acd_pkg;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X2  = 2'd1,
    RATE_X4  = 2'd2,
    RATE_BAD = 2'd3
  } rate_e;

  typedef struct packed {
    logic [1:0] mcs;
    logic [1:0] rate;
    logic       direct;
    logic       bclk_gen;
    logic       port_master;
  } cfg_t;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic cfg_ok(cfg_t c, logic [1:0] direct_mcs);
    return (c.rate != RATE_BAD) && !(c.direct && (c.mcs != direct_mcs));
  endfunction

endpackage

// File: rtl/acd_cfg_decode.sv
module acd_cfg_decode
  import acd_pkg::*;
#(
  parameter int unsigned RATIO_0 = 256,
  parameter int unsigned RATIO_1 = 384,
  parameter int unsigned RATIO_2 = 512,
  parameter int unsigned RATIO_3 = 768,
  parameter int unsigned CNT_W   = 10
) (
  input  cfg_t             cfg_i,
  output logic [CNT_W-1:0] ratio_o,
  output logic [CNT_W-1:0] half_o,
  output logic             bclk_en_o,
  output logic             direct_o
);

  logic [CNT_W-1:0] base;

  always_comb begin
    case (cfg_i.mcs)
      2'd0:    base = CNT_W'(RATIO_0);
      2'd1:    base = CNT_W'(RATIO_1);
      2'd2:    base = CNT_W'(RATIO_2);
      default: base = CNT_W'(RATIO_3);
    endcase
  end

  // master clock is fixed: higher rate families divide the base ratio
  always_comb begin
    case (cfg_i.rate)
      RATE_X1: ratio_o = base;
      RATE_X2: ratio_o = base >> 1;
      RATE_X4: ratio_o = base >> 2;
      default: ratio_o = '0;
    endcase
  end

  assign half_o    = ratio_o >> 1;
  assign bclk_en_o = cfg_i.bclk_gen && !cfg_i.port_master;
  assign direct_o  = cfg_i.direct;

endmodule

// File: rtl/acd_frame_ctrl.sv
module acd_frame_ctrl
  import acd_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter logic [1:0]  DIRECT_MCS = 2'd2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic [CNT_W-1:0] act_ratio_i,
  input  logic [CNT_W-1:0] act_half_i,
  output cfg_t             act_cfg_o,
  output logic             run_o,
  output logic             wrap_o,
  output logic             frame_stb_o,
  output logic             lrclk_o,
  output logic             err_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             err_q;
  cfg_t             act_q;
  logic             wrap;
  logic             load;
  logic             new_ok;

  assign new_ok = cfg_ok(cfg_i, DIRECT_MCS);
  assign wrap   = run_q && (cnt_q == act_ratio_i - CNT_W'(1));
  // settings are only taken while idle or at the last cycle of a frame
  assign load   = !run_q || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      err_q <= 1'b0;
      act_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      run_q <= new_ok;
      err_q <= !new_ok;
      act_q <= cfg_i;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign act_cfg_o   = act_q;
  assign run_o       = run_q;
  assign wrap_o      = wrap;
  assign frame_stb_o = run_q && (cnt_q == '0);
  assign lrclk_o     = run_q && (cnt_q < act_half_i);
  assign err_o       = err_q;

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < act_ratio_i));

  assert_lrclk_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lrclk_o) |-> (run_q && cnt_q == act_half_i));

  assert_cfg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !wrap) |=> $stable(act_q));

endmodule

// File: rtl/acd_bit_gen.sv
module acd_bit_gen #(
  parameter int unsigned CNT_W          = 10,
  parameter int unsigned BITS_PER_FRAME = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             bit_stb_o
);

  localparam logic [CNT_W:0] STEP = (CNT_W+1)'(BITS_PER_FRAME);

  logic [CNT_W-1:0] acc_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   ratio_x;
  logic [CNT_W:0]   acc_d;

  // acc holds (cycle * BITS) mod ratio; a bit starts when it wraps below BITS
  assign sum     = {1'b0, acc_q} + STEP;
  assign ratio_x = {1'b0, ratio_i};
  assign acc_d   = (sum >= ratio_x) ? (sum - ratio_x) : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               acc_q <= '0;
    else if (!run_i || wrap_i) acc_q <= '0;
    else                       acc_q <= acc_d[CNT_W-1:0];
  end

  assign bit_stb_o = run_i && en_i && ({1'b0, acc_q} < STEP);

  assert_acc_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (acc_q < ratio_i));

  assert_bit_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wrap_i) && run_i && en_i) |-> bit_stb_o);

endmodule

// File: rtl/aclk_ratio_div.sv
module aclk_ratio_div
  import acd_pkg::*;
#(
  parameter int unsigned RATIO_0        = 256,
  parameter int unsigned RATIO_1        = 384,
  parameter int unsigned RATIO_2        = 512,
  parameter int unsigned RATIO_3        = 768,
  parameter logic [1:0]  DIRECT_MCS     = 2'd2,
  parameter int unsigned BITS_PER_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mcs_i,
  input  logic [1:0] rate_i,
  input  logic       clk_sel_i,
  input  logic       bclk_gen_i,
  input  logic       port_master_i,
  output logic       lrclk_o,
  output logic       frame_stb_o,
  output logic       bclk_stb_o,
  output logic       core_en_o,
  output logic       err_o
);

  localparam int unsigned MAX_BASE = max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3);
  localparam int unsigned CNT_W    = $clog2(MAX_BASE + 1);

  cfg_t             raw_cfg;
  cfg_t             act_cfg;
  logic [CNT_W-1:0] act_ratio;
  logic [CNT_W-1:0] act_half;
  logic             act_bclk_en;
  logic             act_direct;
  logic             run;
  logic             wrap;

  assign raw_cfg = '{mcs: mcs_i, rate: rate_i, direct: clk_sel_i,
                     bclk_gen: bclk_gen_i, port_master: port_master_i};

  acd_cfg_decode #(
    .RATIO_0 (RATIO_0),
    .RATIO_1 (RATIO_1),
    .RATIO_2 (RATIO_2),
    .RATIO_3 (RATIO_3),
    .CNT_W   (CNT_W)
  ) u_decode (
    .cfg_i     (act_cfg),
    .ratio_o   (act_ratio),
    .half_o    (act_half),
    .bclk_en_o (act_bclk_en),
    .direct_o  (act_direct)
  );

  acd_frame_ctrl #(
    .CNT_W      (CNT_W),
    .DIRECT_MCS (DIRECT_MCS)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (raw_cfg),
    .act_ratio_i (act_ratio),
    .act_half_i  (act_half),
    .act_cfg_o   (act_cfg),
    .run_o       (run),
    .wrap_o      (wrap),
    .frame_stb_o (frame_stb_o),
    .lrclk_o     (lrclk_o),
    .err_o       (err_o)
  );

  acd_bit_gen #(
    .CNT_W          (CNT_W),
    .BITS_PER_FRAME (BITS_PER_FRAME)
  ) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .wrap_i    (wrap),
    .en_i      (act_bclk_en),
    .ratio_i   (act_ratio),
    .bit_stb_o (bclk_stb_o)
  );

  assign core_en_o = run && act_direct;

  assert_err_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!lrclk_o && !frame_stb_o && !bclk_stb_o && !core_en_o));

  assert_core_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_o |-> (!err_o && act_cfg.mcs == DIRECT_MCS));

endmodule

// File: tb/aclk_ratio_div_test.sv
module aclk_ratio_div_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mcs = 2'd0;
  logic [1:0] rate = 2'd0;
  logic       sel = 1'b0;
  logic       gen = 1'b1;
  logic       mst = 1'b0;
  logic       lrclk, frame_stb, bclk_stb, core_en, err;

  always #2 clk = ~clk;

  aclk_ratio_div uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mcs_i         (mcs),
    .rate_i        (rate),
    .clk_sel_i     (sel),
    .bclk_gen_i    (gen),
    .port_master_i (mst),
    .lrclk_o       (lrclk),
    .frame_stb_o   (frame_stb),
    .bclk_stb_o    (bclk_stb),
    .core_en_o     (core_en),
    .err_o         (err)
  );

  typedef struct {
    int    len;
    int    hi;
    int    bits;
    int    core;
    int    gmin;
    int    gmax;
    string len_tag;
    string bit_tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;

  int cm = 0, cr = 0;
  bit cs = 0, cg = 1, cms = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff(int m, int r);
    int b[4] = '{256, 384, 512, 768};
    return b[m] >> r;
  endfunction

  task automatic push(int m, int r, bit s, bit g, bit ms, string tag);
    exp_t e;
    bit   en = g && !ms;
    e.len     = eff(m, r);
    e.hi      = e.len / 2;
    e.bits    = en ? 64 : 0;
    e.core    = s ? e.len : 0;
    e.gmin    = e.len / 64;
    e.gmax    = (e.len + 63) / 64;
    e.len_tag = tag;
    e.bit_tag = en ? "R3" : "R4";
    q.push_back(e);
  endtask

  // monitor
  bit m_on = 0;
  int m_len, m_hi, m_bits, m_core, m_last, m_first, m_gmin, m_gmax;

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_on && (frame_stb || err)) begin
        exp_t e;
        if (m_bits > 0) begin
          if (m_len - m_last < m_gmin) m_gmin = m_len - m_last;
          if (m_len - m_last > m_gmax) m_gmax = m_len - m_last;
        end
        if (q.size() == 0) begin
          chk(0, "R5", "unexpected frame", m_len, 0);
        end else begin
          e = q.pop_front();
          chk(m_len == e.len, e.len_tag, "frame length", m_len, e.len);
          chk(m_hi == e.hi, "R2", "lrclk high cycles", m_hi, e.hi);
          chk(m_bits == e.bits, e.bit_tag, "bit strobes", m_bits, e.bits);
          chk(m_core == e.core, "R7", "core enable cycles", m_core, e.core);
          if (e.bits > 0) begin
            chk(m_first == 0, "R3", "first bit position", m_first, 0);
            chk(m_gmin == e.gmin, "R3", "min bit gap", m_gmin, e.gmin);
            chk(m_gmax == e.gmax, "R3", "max bit gap", m_gmax, e.gmax);
          end
        end
        m_on = 0;
      end
      if (frame_stb) begin
        m_on = 1; m_len = 0; m_hi = 0; m_bits = 0; m_core = 0;
        m_last = 0; m_first = -1; m_gmin = 1000000; m_gmax = 0;
      end
      if (m_on) begin
        if (bclk_stb) begin
          if (m_bits > 0) begin
            if (m_len - m_last < m_gmin) m_gmin = m_len - m_last;
            if (m_len - m_last > m_gmax) m_gmax = m_len - m_last;
          end else begin
            m_first = m_len;
          end
          m_last = m_len;
          m_bits++;
        end
        if (lrclk) m_hi++;
        if (core_en) m_core++;
        m_len++;
      end
    end
  end

  task automatic apply(int m, int r, bit s, bit g, bit ms, int n);
    push(cm, cr, cs, cg, cms, "R5");  // frame in progress keeps old setting
    mcs = 2'(m); rate = 2'(r); sel = s; gen = g; mst = ms;
    for (int i = 0; i < n; i++) push(m, r, s, g, ms, "R1");
    cm = m; cr = r; cs = s; cg = g; cms = ms;
    wait (q.size() == 0);
  endtask

  task automatic go_bad(int m, int r, bit s);
    push(cm, cr, cs, cg, cms, "R5");
    mcs = 2'(m); rate = 2'(r); sel = s;
    wait (q.size() == 0);
    chk(err == 1'b1, "R6", "err after invalid", err, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(err == 1'b1, "R6", "err held", err, 1);
      chk({lrclk, frame_stb, bclk_stb, core_en} == 4'b0, "R6", "outputs quiet",
          {lrclk, frame_stb, bclk_stb, core_en}, 0);
    end
  endtask

  task automatic recover(int m, int r, bit s, bit g, bit ms, int n);
    mcs = 2'(m); rate = 2'(r); sel = s; gen = g; mst = ms;
    for (int i = 0; i < n; i++) push(m, r, s, g, ms, "R9");
    cm = m; cr = r; cs = s; cg = g; cms = ms;
    @(negedge clk);
    chk(frame_stb == 1'b1, "R9", "frame restarts", frame_stb, 1);
    chk(err == 1'b0, "R9", "err cleared", err, 0);
    wait (q.size() == 0);
  endtask

  bit done = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({lrclk, frame_stb, bclk_stb, core_en, err} == 5'b0, "R8", "reset outputs",
          {lrclk, frame_stb, bclk_stb, core_en, err}, 0);
    end
    push(0, 0, 0, 1, 0, "R8");
    push(0, 0, 0, 1, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_stb == 1'b1, "R8", "first frame strobe", frame_stb, 1);
    chk(lrclk == 1'b1, "R8", "first frame lrclk", lrclk, 1);
    wait (q.size() == 0);

    apply(1, 0, 0, 1, 0, 2);
    apply(2, 0, 0, 1, 0, 2);
    apply(3, 0, 0, 1, 0, 2);
    apply(0, 1, 0, 1, 0, 2);
    apply(1, 1, 0, 1, 0, 2);
    apply(3, 1, 0, 1, 0, 2);
    apply(0, 2, 0, 1, 0, 2);
    apply(1, 2, 0, 1, 0, 3);  // 1.5 cycles per bit
    apply(3, 2, 0, 1, 0, 2);
    apply(2, 2, 1, 1, 0, 2);  // direct mode R7
    apply(2, 0, 1, 1, 0, 2);
    apply(1, 1, 0, 0, 0, 2);  // R4 generation off
    apply(1, 1, 0, 1, 1, 2);  // R4 port master
    apply(1, 2, 0, 1, 0, 2);
    go_bad(1, 3, 0);
    recover(3, 0, 0, 1, 0, 2);
    go_bad(0, 1, 1);
    recover(1, 2, 0, 1, 0, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule